// File: doc/BRIEF.md
# SPD Memory Transaction Controller

This block is the transaction layer of a 512-byte serial-presence-detect style memory. A byte-level I2C slave front end hands it start and stop pulses, each byte written by the master, and a request each time it needs a byte to send. The block decides the ACK or NACK for every received byte. It serves two command spaces: plain memory access, and a configuration space that selects the visible half of the array and manages write protection. The 512-byte storage array sits inside the block.

Only one 256-byte half of the array is visible at a time. A single half-select bit chooses the half, and a probe command reports which half is selected through its ACK or NACK. Each of the three lower 128-byte quadrants can be locked on its own. A single command unlocks all of them. Every case answers with a fixed ACK/NACK pattern. Memory writes collect in a 16-byte page buffer and are committed at stop. A self-timed write cycle follows. During that cycle control bytes are refused, so the master can poll until the cycle ends.

Top module: `spd_xact_ctrl`

## Requirements
- R1: A control byte of the form 1010_ccc_r (bits 7..4 = 1010, bits 3..1 = chip select, bit 0 = 1 for read) is ACKed when ccc equals `cs_strap_i` and no write cycle is running. On a chip-select mismatch the byte is NACKed and every later byte up to the next start is NACKed. Each received byte produces exactly one `ack_valid_o` pulse, one cycle after `rx_valid_i`.
- R2: Byte 0x6C selects the lower half and byte 0x6E selects the upper half. The block ACKs either byte and NACKs the two data bytes that follow it. The full array address is {half bit, 8-bit pointer}.
- R3: Byte 0x6D (probe) is ACKed when the lower half is selected and NACKed when the upper half is selected.
- R4: The half-select bit is 0 after reset. A stop that arrives with no byte received since the preceding start acts as a software reset and clears the bit.
- R5: In a memory write (0x1010 command with bit 0 = 0, then an address byte, then data bytes), every data byte into an unlocked quadrant is ACKed. The low 4 bits of the pointer step after each data byte and wrap inside the 16-byte page. The data is committed to the array at stop.
- R6: A memory read returns the byte at {half bit, pointer} on each `tx_req_i`, on `tx_data_o` one cycle later. The pointer then steps and wraps inside the selected 256-byte half. After a write, the pointer rests one column past the last byte written, within the same page.
- R7: Lock commands 0x62, 0x68 and 0x6A target quadrants 0, 1 and 2. On an unlocked quadrant the block ACKs the command and both following bytes, locks the quadrant at stop and starts a write cycle. On an already locked quadrant it NACKs all three bytes and starts no write cycle.
- R8: Byte 0x66 (unlock all) is ACKed along with both following bytes. At stop it clears every lock bit and starts a write cycle.
- R9: A memory write whose quadrant ({half bit, address bit 7}) is locked ACKs the control and address bytes and NACKs every data byte. It leaves the array unchanged and starts no write cycle.
- R10: After a committed write or a lock change, every control byte is NACKed for `T_WR` cycles. After that, control bytes are ACKed again.
- R11: A repeated start before stop discards the buffered write data, and the array keeps its old contents. The pointer loaded by the address byte stays in place, so a following read continues from there.
- R12: Configuration-space bytes other than 0x62, 0x66, 0x68, 0x6A, 0x6C, 0x6D and 0x6E are NACKed, and so is any control byte whose upper nibble is neither 1010 nor 0110.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_strap_i | input | 3 | Strapped chip-select value |
| start_i | input | 1 | Start or repeated start seen (one-cycle pulse) |
| stop_i | input | 1 | Stop seen (one-cycle pulse) |
| rx_valid_i | input | 1 | Byte received from master (one-cycle pulse) |
| rx_byte_i | input | 8 | Received byte |
| tx_req_i | input | 1 | Front end needs the next byte to send |
| ack_valid_o | output | 1 | ACK decision valid for the last received byte |
| ack_o | output | 1 | 1 = ACK, 0 = NACK |
| tx_data_o | output | 8 | Byte to send, valid the cycle after `tx_req_i` |

## Verification
The array is filled page by page in both halves with an arithmetic pattern and then read back sequentially through each half, including the wrap to address 0. This separates half-select errors from pointer-stepping errors. A write that starts mid-page and runs past the page end shows whether column wrap and the resting pointer are correct. The lock sweep tries a write into every quadrant after each quadrant is locked, which tells quadrant decode apart from a single global lock. Aborted writes, software reset, busy polling and malformed control bytes each get their own ACK/NACK pattern check.

// File: rtl/spd_pkg.sv
package spd_pkg;

   typedef enum logic [3:0] {
      ST_IDLE, ST_CTRL, ST_MADDR, ST_MDATA, ST_MREAD,
      ST_HSEL, ST_PROBE, ST_LOCK, ST_DROP
   } xact_st_e;

   typedef enum logic [2:0] {
      CMD_BAD, CMD_MEM_WR, CMD_MEM_RD, CMD_SEL_LO, CMD_SEL_HI,
      CMD_PROBE, CMD_LOCK, CMD_UNLOCK
   } cmd_kind_e;

   typedef struct packed {
      cmd_kind_e   kind;
      logic [1:0]  quad;
   } cmd_info_t;

   localparam logic [3:0] NIB_MEM = 4'b1010;
   localparam logic [3:0] NIB_CFG = 4'b0110;

endpackage

// File: rtl/spd_cmd_decode.sv
module spd_cmd_decode
   import spd_pkg::*;
#(
   parameter int CS_W = 3
) (
   input  logic [7:0]      ctrl_i,
   input  logic [CS_W-1:0] strap_i,
   output cmd_info_t       info_o
);
   localparam int OP_W = CS_W + 1;

   initial begin : chk_width
      if (4 + CS_W + 1 != 8) $fatal(1, "control byte must be 8 bits");
   end

   logic [OP_W-1:0] op;
   assign op = ctrl_i[OP_W-1:0];

   always_comb begin
      info_o.kind = CMD_BAD;
      info_o.quad = 2'd0;
      if (ctrl_i[7:4] == NIB_MEM) begin
         if (ctrl_i[CS_W:1] == strap_i)
            info_o.kind = ctrl_i[0] ? CMD_MEM_RD : CMD_MEM_WR;
      end else if (ctrl_i[7:4] == NIB_CFG) begin
         case (op)
            4'b0010: begin info_o.kind = CMD_LOCK; info_o.quad = 2'd0; end
            4'b1000: begin info_o.kind = CMD_LOCK; info_o.quad = 2'd1; end
            4'b1010: begin info_o.kind = CMD_LOCK; info_o.quad = 2'd2; end
            4'b0110: info_o.kind = CMD_UNLOCK;
            4'b1100: info_o.kind = CMD_SEL_LO;
            4'b1110: info_o.kind = CMD_SEL_HI;
            4'b1101: info_o.kind = CMD_PROBE;
            default: info_o.kind = CMD_BAD;
         endcase
      end
   end
endmodule

// File: rtl/spd_wr_timer.sv
module spd_wr_timer #(
   parameter int T_WR = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic kick_i,
   output logic busy_o
);
   localparam int CNT_W = $clog2(T_WR + 1);

   initial begin : chk_t
      if (T_WR < 1) $fatal(1, "T_WR must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (kick_i)        cnt_q <= CNT_W'(T_WR);
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/spd_page_buf.sv
module spd_page_buf #(
   parameter int DATA_W = 8,
   parameter int COL_W  = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         clr_i,
   input  logic                         we_i,
   input  logic [COL_W-1:0]             col_i,
   input  logic [DATA_W-1:0]            data_i,
   output logic [(1<<COL_W)-1:0]        vld_o,
   output logic [(1<<COL_W)*DATA_W-1:0] data_o
);
   localparam int PAGE_LEN = 1 << COL_W;

   for (genvar c = 0; c < PAGE_LEN; c++) begin : g_col
      logic              v_q;
      logic [DATA_W-1:0] d_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            d_q <= '0;
         end else if (clr_i) begin
            v_q <= 1'b0;
         end else if (we_i && col_i == COL_W'(c)) begin
            v_q <= 1'b1;
            d_q <= data_i;
         end
      end
      assign vld_o[c]                       = v_q;
      assign data_o[c*DATA_W +: DATA_W]     = d_q;
   end
endmodule

// File: rtl/spd_mem_array.sv
module spd_mem_array #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 9,
   parameter int COL_W  = 4
) (
   input  logic                         clk,
   input  logic                         pg_we_i,
   input  logic [ADDR_W-COL_W-1:0]      row_i,
   input  logic [(1<<COL_W)-1:0]        mask_i,
   input  logic [(1<<COL_W)*DATA_W-1:0] data_i,
   input  logic [ADDR_W-1:0]            rd_addr_i,
   output logic [DATA_W-1:0]            rd_data_o
);
   localparam int DEPTH    = 1 << ADDR_W;
   localparam int PAGE_LEN = 1 << COL_W;

   initial begin : chk_geom
      if (COL_W >= ADDR_W) $fatal(1, "page larger than array");
      if (DEPTH > 4096)    $fatal(1, "array too deep");
   end

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (pg_we_i) begin
         for (int c = 0; c < PAGE_LEN; c++) begin
            if (mask_i[c])
               mem[{row_i, COL_W'(c)}] <= data_i[c*DATA_W +: DATA_W];
         end
      end
   end

   assign rd_data_o = mem[rd_addr_i];
endmodule

// File: rtl/spd_xact_ctrl.sv
module spd_xact_ctrl
   import spd_pkg::*;
#(
   parameter int HALF_AW = 8,
   parameter int COL_W   = 4,
   parameter int DATA_W  = 8,
   parameter int CS_W    = 3,
   parameter int N_QUAD  = 4,
   parameter int T_WR    = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CS_W-1:0]   cs_strap_i,
   input  logic              start_i,
   input  logic              stop_i,
   input  logic              rx_valid_i,
   input  logic [7:0]        rx_byte_i,
   input  logic              tx_req_i,
   output logic              ack_valid_o,
   output logic              ack_o,
   output logic [DATA_W-1:0] tx_data_o
);
   localparam int ADDR_W   = HALF_AW + 1;
   localparam int ROW_W    = ADDR_W - COL_W;
   localparam int PAGE_LEN = 1 << COL_W;
   localparam int QD_W     = $clog2(N_QUAD);

   initial begin : chk_params
      if (N_QUAD != 4)      $fatal(1, "four quadrants expected");
      if (HALF_AW != 8)     $fatal(1, "address byte spans one half");
      if (DATA_W != 8)      $fatal(1, "byte wide data expected");
   end

   xact_st_e            st_q;
   logic                page_q;
   logic [N_QUAD-1:0]   prot_q;
   logic [HALF_AW-1:0]  ptr_q;
   logic                wr_prot_q;
   logic                lock_go_q;
   logic                lock_clr_q;
   logic [QD_W-1:0]     lock_quad_q;
   logic                ack_valid_q, ack_q;
   logic [DATA_W-1:0]   tx_q;

   cmd_info_t           cinfo;
   logic                busy;
   logic                mem_we;
   logic                lock_apply;
   logic                buf_we, buf_clr;
   logic [PAGE_LEN-1:0] buf_vld;
   logic [PAGE_LEN*DATA_W-1:0] buf_data;
   logic [DATA_W-1:0]   rd_data;
   logic [QD_W-1:0]     addr_quad;
   logic                in_ctrl;

   spd_cmd_decode #(.CS_W(CS_W)) u_dec (
      .ctrl_i (rx_byte_i),
      .strap_i(cs_strap_i),
      .info_o (cinfo)
   );

   spd_wr_timer #(.T_WR(T_WR)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .kick_i(mem_we | lock_apply),
      .busy_o(busy)
   );

   spd_page_buf #(.DATA_W(DATA_W), .COL_W(COL_W)) u_buf (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (buf_clr),
      .we_i  (buf_we),
      .col_i (ptr_q[COL_W-1:0]),
      .data_i(rx_byte_i),
      .vld_o (buf_vld),
      .data_o(buf_data)
   );

   spd_mem_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .COL_W(COL_W)) u_mem (
      .clk      (clk),
      .pg_we_i  (mem_we),
      .row_i    ({page_q, ptr_q[HALF_AW-1:COL_W]}),
      .mask_i   (buf_vld),
      .data_i   (buf_data),
      .rd_addr_i({page_q, ptr_q}),
      .rd_data_o(rd_data)
   );

   assign in_ctrl    = (st_q == ST_CTRL);
   assign addr_quad  = {page_q, rx_byte_i[HALF_AW-1]};
   assign mem_we     = stop_i && st_q == ST_MDATA && !wr_prot_q && (|buf_vld);
   assign lock_apply = stop_i && st_q == ST_LOCK && lock_go_q;
   assign buf_we     = rx_valid_i && !start_i && !stop_i && st_q == ST_MDATA && !wr_prot_q;
   assign buf_clr    = start_i || stop_i;

   // transaction state, ACK decision and pointer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         page_q      <= 1'b0;
         prot_q      <= '0;
         ptr_q       <= '0;
         wr_prot_q   <= 1'b0;
         lock_go_q   <= 1'b0;
         lock_clr_q  <= 1'b0;
         lock_quad_q <= '0;
         ack_valid_q <= 1'b0;
         ack_q       <= 1'b0;
      end else begin
         ack_valid_q <= rx_valid_i;
         ack_q       <= 1'b0;
         if (start_i) begin
            st_q <= ST_CTRL;
         end else if (stop_i) begin
            if (st_q == ST_CTRL) page_q <= 1'b0;
            if (lock_apply) begin
               if (lock_clr_q) prot_q <= '0;
               else            prot_q[lock_quad_q] <= 1'b1;
            end
            st_q <= ST_IDLE;
         end else if (rx_valid_i) begin
            unique case (st_q)
               ST_CTRL: begin
                  if (busy) begin
                     st_q <= ST_DROP;
                  end else begin
                     unique case (cinfo.kind)
                        CMD_MEM_WR: begin ack_q <= 1'b1; st_q <= ST_MADDR; end
                        CMD_MEM_RD: begin ack_q <= 1'b1; st_q <= ST_MREAD; end
                        CMD_SEL_LO: begin ack_q <= 1'b1; page_q <= 1'b0; st_q <= ST_HSEL; end
                        CMD_SEL_HI: begin ack_q <= 1'b1; page_q <= 1'b1; st_q <= ST_HSEL; end
                        CMD_PROBE:  begin ack_q <= !page_q; st_q <= ST_PROBE; end
                        CMD_LOCK: begin
                           lock_go_q   <= !prot_q[cinfo.quad];
                           ack_q       <= !prot_q[cinfo.quad];
                           lock_clr_q  <= 1'b0;
                           lock_quad_q <= cinfo.quad;
                           st_q        <= ST_LOCK;
                        end
                        CMD_UNLOCK: begin
                           lock_go_q  <= 1'b1;
                           ack_q      <= 1'b1;
                           lock_clr_q <= 1'b1;
                           st_q       <= ST_LOCK;
                        end
                        default: st_q <= ST_DROP;
                     endcase
                  end
               end
               ST_MADDR: begin
                  ptr_q     <= rx_byte_i;
                  wr_prot_q <= prot_q[addr_quad];
                  ack_q     <= 1'b1;
                  st_q      <= ST_MDATA;
               end
               ST_MDATA: begin
                  ack_q <= !wr_prot_q;
                  if (!wr_prot_q)
                     ptr_q[COL_W-1:0] <= ptr_q[COL_W-1:0] + 1'b1;
               end
               ST_LOCK: ack_q <= lock_go_q;
               default: ack_q <= 1'b0;
            endcase
         end else if (tx_req_i && st_q == ST_MREAD) begin
            ptr_q <= ptr_q + 1'b1;
         end
      end
   end

   // transmit byte register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        tx_q <= '1;
      else if (tx_req_i) tx_q <= (st_q == ST_MREAD) ? rd_data : '1;
   end

   assign ack_valid_o = ack_valid_q;
   assign ack_o       = ack_q;
   assign tx_data_o   = tx_q;
endmodule

// File: rtl/spd_xact_chk.sv
module spd_xact_chk #(
   parameter int N_QUAD = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rx_valid_i,
   input logic              stop_i,
   input logic              ack_valid_o,
   input logic              ack_o,
   input logic              busy,
   input logic              in_ctrl,
   input logic              page_q,
   input logic [N_QUAD-1:0] prot_q,
   input logic              mem_we,
   input logic [1:0]        wr_quad
);
   // R1: one ACK decision per received byte, one cycle later
   assert_ack_per_byte_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ack_valid_o == $past(rx_valid_i));

   // R4: stop straight after start clears the half-select bit
   assert_swreset_page_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_i && in_ctrl) |=> !page_q);

   // R7: a lock bit only rises on a stop
   assert_lock_at_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (|(prot_q & ~$past(prot_q))) |-> $past(stop_i));

   // R9: the array is never written inside a locked quadrant
   assert_no_locked_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> !prot_q[wr_quad]);

   // R10: control bytes during a write cycle are refused
   assert_busy_nack_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid_i && in_ctrl && busy) |=> (ack_valid_o && !ack_o));

   // R10: a write cycle only begins on a stop
   assert_busy_from_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(stop_i));
endmodule

bind spd_xact_ctrl spd_xact_chk #(.N_QUAD(N_QUAD)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rx_valid_i (rx_valid_i),
   .stop_i     (stop_i),
   .ack_valid_o(ack_valid_o),
   .ack_o      (ack_o),
   .busy       (busy),
   .in_ctrl    (in_ctrl),
   .page_q     (page_q),
   .prot_q     (prot_q),
   .mem_we     (mem_we),
   .wr_quad    ({page_q, ptr_q[HALF_AW-1]})
);

// File: tb/test_spd_xact_ctrl.sv
module test_spd_xact_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int WR_T       = 32;
   localparam logic [2:0] STRAP = 3'b101;
   localparam logic [7:0] C_WR = {4'b1010, STRAP, 1'b0};
   localparam logic [7:0] C_RD = {4'b1010, STRAP, 1'b1};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0, stop_i = 1'b0, rx_valid_i = 1'b0, tx_req_i = 1'b0;
   logic [7:0] rx_byte_i = 8'h00;
   logic       ack_valid_o, ack_o;
   logic [7:0] tx_data_o;

   int checks = 0;
   int errors = 0;
   bit done   = 0;
   logic [7:0] exp_mem [512];
   bit         exp_lock [4];

   always #(CLK_PERIOD/2) clk = ~clk;

   spd_xact_ctrl #(.T_WR(WR_T)) i_spd_xact_ctrl (
      .clk(clk), .rst_n(rst_n), .cs_strap_i(STRAP),
      .start_i(start_i), .stop_i(stop_i),
      .rx_valid_i(rx_valid_i), .rx_byte_i(rx_byte_i), .tx_req_i(tx_req_i),
      .ack_valid_o(ack_valid_o), .ack_o(ack_o), .tx_data_o(tx_data_o)
   );

   function automatic logic [7:0] pat(int a);
      return 8'((a * 37 + 11) ^ (a >> 8));
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_start();
      @(negedge clk); start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
   endtask

   task automatic do_stop();
      @(negedge clk); stop_i = 1'b1;
      @(negedge clk); stop_i = 1'b0;
   endtask

   task automatic send(input logic [7:0] b, output bit a);
      @(negedge clk); rx_byte_i = b; rx_valid_i = 1'b1;
      @(negedge clk); rx_valid_i = 1'b0;
      if (!ack_valid_o) check(1'b0, "R1 ack_valid", 0, 1);
      a = ack_o;
   endtask

   task automatic send_exp(input logic [7:0] b, input bit e, input string req);
      bit a;
      send(b, a);
      check(a == e, req, a, e);
   endtask

   task automatic rd(output logic [7:0] d);
      @(negedge clk); tx_req_i = 1'b1;
      @(negedge clk); tx_req_i = 1'b0;
      d = tx_data_o;
   endtask

   task automatic sel_half(bit h);
      do_start();
      send_exp(h ? 8'h6E : 8'h6C, 1'b1, "R2 select ack");
      send_exp(8'h00, 1'b0, "R2 data1 nack");
      send_exp(8'h00, 1'b0, "R2 data2 nack");
      do_stop();
      idle(2);
   endtask

   task automatic read_at(input logic [7:0] a, output logic [7:0] d);
      bit k;
      do_start(); send(C_WR, k); send(a, k);
      do_start(); send(C_RD, k);
      rd(d);
      do_stop();
      idle(2);
   endtask

   task automatic lock_cmd(logic [7:0] code, bit e, string req);
      do_start();
      send_exp(code, e, req);
      send_exp(8'h00, e, req);
      send_exp(8'h00, e, req);
      do_stop();
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got %0h expected %0h", 1, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] d;
      bit a;
      idle(3);
      check(ack_valid_o == 1'b0, "R1 reset ack_valid", ack_valid_o, 0);
      rst_n = 1'b1;
      idle(2);

      // R4 / R3: lower half after reset
      do_start(); send_exp(8'h6D, 1'b1, "R4 R3 probe after reset"); rd(d); rd(d); do_stop();

      // R12: malformed control bytes
      do_start(); send_exp(8'h60, 1'b0, "R12 cfg 0x60"); do_stop();
      do_start(); send_exp(8'h64, 1'b0, "R12 cfg 0x64"); do_stop();
      do_start(); send_exp(8'h63, 1'b0, "R12 cfg 0x63"); do_stop();
      do_start(); send_exp(8'h50, 1'b0, "R12 nibble 0101"); do_stop();
      // R1: chip select mismatch, rest ignored
      do_start();
      send_exp(8'hA0, 1'b0, "R1 cs mismatch");
      send_exp(8'h10, 1'b0, "R1 ignored addr");
      send_exp(8'h55, 1'b0, "R1 ignored data");
      do_stop();

      // R5: fill both halves page by page
      for (int h = 0; h < 2; h++) begin
         sel_half(h[0]);
         for (int r = 0; r < 16; r++) begin
            do_start();
            send_exp(C_WR, 1'b1, "R1 write ctrl");
            send_exp(8'(r * 16), 1'b1, "R5 address ack");
            for (int c = 0; c < 16; c++) begin
               exp_mem[h*256 + r*16 + c] = pat(h*256 + r*16 + c);
               send_exp(pat(h*256 + r*16 + c), 1'b1, "R5 data ack");
            end
            do_stop();
            idle(WR_T + 4);
         end
      end

      // R6 / R3 / R2: sequential read through each half with wrap
      for (int h = 0; h < 2; h++) begin
         sel_half(h[0]);
         do_start(); send_exp(8'h6D, h == 0, "R3 probe"); rd(d); rd(d); do_stop();
         do_start(); send(C_WR, a); send(8'h00, a);
         do_start(); send_exp(C_RD, 1'b1, "R1 read ctrl");
         for (int k = 0; k < 257; k++) begin
            rd(d);
            check(d == exp_mem[h*256 + (k % 256)], "R6 R2 sequential read", d, exp_mem[h*256 + (k % 256)]);
         end
         do_stop(); idle(2);
      end

      // R5 / R6: page wrap, resting pointer
      sel_half(1'b0);
      do_start(); send(C_WR, a); send_exp(8'h3C, 1'b1, "R5 addr");
      for (int k = 0; k < 6; k++) begin
         int col;
         col = (12 + k) % 16;
         exp_mem[48 + col] = 8'(8'hC0 + k);
         send_exp(8'(8'hC0 + k), 1'b1, "R5 wrap data");
      end
      do_stop(); idle(WR_T + 4);
      do_start(); send(C_RD, a); rd(d);
      check(d == exp_mem[8'h32], "R6 pointer after write", d, exp_mem[8'h32]);
      do_stop(); idle(2);
      for (int k = 0; k < 16; k++) begin
         read_at(8'(48 + k), d);
         check(d == exp_mem[48 + k], "R5 page wrap contents", d, exp_mem[48 + k]);
      end

      // R10: polling during the write cycle
      do_start(); send(C_WR, a); send(8'h70, a); send(8'h99, a); do_stop();
      exp_mem[8'h70] = 8'h99;
      do_start(); send_exp(C_WR, 1'b0, "R10 busy nack"); do_stop();
      do_start(); send_exp(8'h6D, 1'b0, "R10 busy probe nack"); do_stop();
      idle(WR_T + 2);
      do_start(); send_exp(C_WR, 1'b1, "R10 ack after cycle"); do_stop();
      read_at(8'h70, d);
      check(d == 8'h99, "R10 committed byte", d, 8'h99);

      // R11: repeated start discards buffered data
      do_start(); send(C_WR, a); send(8'h50, a); send_exp(8'h11, 1'b1, "R11 data ack");
      do_start(); send_exp(C_RD, 1'b1, "R11 no busy");
      rd(d);
      check(d == exp_mem[8'h51], "R11 pointer kept", d, exp_mem[8'h51]);
      do_stop(); idle(2);
      read_at(8'h50, d);
      check(d == exp_mem[8'h50], "R11 old data kept", d, exp_mem[8'h50]);

      // R4: software reset clears half select
      sel_half(1'b1);
      do_start(); send_exp(8'h6D, 1'b0, "R3 probe upper"); do_stop();
      do_start(); do_stop();
      do_start(); send_exp(8'h6D, 1'b1, "R4 probe after sw reset"); do_stop();

      // R7 / R9: lock sweep
      for (int q = 0; q < 3; q++) begin
         logic [7:0] code;
         code = (q == 0) ? 8'h62 : (q == 1) ? 8'h68 : 8'h6A;
         lock_cmd(code, 1'b1, "R7 lock ack");
         idle(WR_T + 4);
         exp_lock[q] = 1'b1;
         lock_cmd(code, 1'b0, "R7 relock nack");
         do_start(); send_exp(C_WR, 1'b1, "R7 no write cycle"); do_stop();
         for (int qq = 0; qq < 4; qq++) begin
            int fa;
            fa = qq * 128 + 16 + q;
            sel_half(qq[1]);
            do_start();
            send_exp(C_WR, 1'b1, "R9 ctrl ack");
            send_exp(8'(fa % 256), 1'b1, "R9 addr ack");
            send_exp(8'(8'h5A ^ fa), !exp_lock[qq], "R9 data ack");
            do_stop();
            if (!exp_lock[qq]) exp_mem[fa] = 8'(8'h5A ^ fa);
            idle(WR_T + 4);
            read_at(8'(fa % 256), d);
            check(d == exp_mem[fa], "R9 contents", d, exp_mem[fa]);
         end
      end

      // R8: unlock all
      lock_cmd(8'h66, 1'b1, "R8 unlock ack");
      do_start(); send_exp(C_WR, 1'b0, "R8 write cycle started"); do_stop();
      idle(WR_T + 4);
      sel_half(1'b0);
      do_start(); send(C_WR, a); send(8'h05, a);
      send_exp(8'h77, 1'b1, "R8 quadrant 0 writable"); do_stop();
      idle(WR_T + 4);
      read_at(8'h05, d);
      check(d == 8'h77, "R8 write after unlock", d, 8'h77);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule